// File: doc/BRIEF.md
# Start-bit framed serial display latch

This block receives a display word over a slow three-wire serial link and holds it on a set of parallel segment outputs. The link has no load strobe. The sender puts a single one bit in front of 35 data bits, which gives 36 serial clocks per frame. That leading one travels down a 36-stage shift chain. When it reaches the last stage, the frame is complete.

At that moment the 35 data bits are copied into an output latch while the serial clock is still high. On the next low phase of the serial clock the chain is cleared, ready for the next frame. An active-low enable gates the data line. While the enable is inactive, the chain takes in zeros whatever the data line does.

All three serial inputs are synchronised into the system clock domain, and the edges of the serial clock are detected there. Besides the full 35-bit word, the block drives a 14-output view. That view is fed from four groups of frame positions, with the groups eight positions apart.

A small controller sequences the chain with three states:
- `ST_COLLECT` shifts bits in. It takes transition T_FULL to `ST_HOLD_HIGH` when the start bit reaches the last stage; this transition issues the latch.
- `ST_HOLD_HIGH` waits for the serial clock to fall. It takes transition T_FALL to `ST_FLUSH`.
- `ST_FLUSH` clears the chain for one system cycle. It takes transition T_DONE back to `ST_COLLECT`.

Top module: `serial_display_latch`

## Requirements
- R1: A synchronous active-high reset drives `seg_word`, `seg_narrow` and `latch_strobe` to zero, meaning every segment is off.
- R2: After a one bit followed by 35 data bits has been clocked in on rising serial clock edges, the k-th data bit (k from 1 to 35) appears on `seg_word[k-1]`. The output is updated during the high phase of the 36th serial clock.
- R3: `latch_strobe` is high for exactly one system cycle for each completed frame, in the cycle in which the new word first appears. It is never high otherwise.
- R4: A frame cut short, with fewer than 36 serial clocks since the last clear, causes no latch. `seg_word` and `seg_narrow` keep their previous values.
- R5: While `den_n` is high, a rising serial clock edge shifts a zero into the chain, whatever the level on `sdata`.
- R6: After a latch, the whole chain is cleared on the following low phase of the serial clock. Data bits left over from a frame can therefore never start another frame; only a fresh one bit can.
- R7: The clear never loses a bit sampled by a later rising edge. A start bit on serial clock 37 begins the next frame, and that frame latches on serial clock 72.
- R8: `seg_narrow[j]` equals `seg_word[4 + 8*(j/4) + (j%4)]` for j from 0 to 13. This uses frame data positions 5 to 8, 13 to 16, 21 to 24 and 29 to 30. The other 21 data positions do not reach this output.
- R9: `sdata` and `den_n` are sampled only at the rising edge of the serial clock. Changes during the high phase have no effect.
- R10: Sending 36 zeros, then a one, then 36 zeros leaves every output at zero, whatever partial frame was in the chain before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock, asynchronous to `clk` |
| sdata_in | input | 1 | Serial data line |
| den_n_in | input | 1 | Data enable, active low; when high, zeros are shifted in |
| seg_word | output | 35 | Latched data word; bit k-1 holds frame data bit k |
| seg_narrow | output | 14 | Reduced 14-output view of the latched word |
| latch_strobe | output | 1 | One-cycle pulse when a new word is latched |

## Verification
The bench goes after these corner cases:
- A walking one through every data position. A design with the wrong shift direction or order would light the wrong segment, and a wrong 14-output decode would pick a don't-care group.
- A frame made of all ones followed by 40 zeros. A design that skipped or mistimed the clear would let the leftover ones reach the last stage and latch a phantom frame.
- Frames sent back to back. A clear that swallowed the next bit would lose the second start bit and never latch.
- A truncated frame with the enable held inactive, followed by the blanking sequence. This exposes a design that gates the wrong line, latches early, or fails to flush what a partial frame left behind.
- The data line toggled during every high phase. A design sampling on the wrong edge or level would pick up the toggled value.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    // Frame geometry
    localparam int unsigned DATA_BITS    = 35;
    localparam int unsigned FRAME_LEN    = DATA_BITS + 1;

    // Reduced output view: groups of four, eight positions apart
    localparam int unsigned NARROW_W     = 14;
    localparam int unsigned GROUP_W      = 4;
    localparam int unsigned GROUP_STRIDE = 8;
    localparam int unsigned FIRST_USED   = 5;   // 1-based data position of narrow bit 0

    typedef enum logic [1:0] {
        ST_COLLECT   = 2'd0,
        ST_HOLD_HIGH = 2'd1,
        ST_FLUSH     = 2'd2
    } fsm_state_t;

    // 0-based word index feeding narrow output j
    function automatic int unsigned narrow_src(input int unsigned j);
        return (FIRST_USED - 1) + (j / GROUP_W) * GROUP_STRIDE + (j % GROUP_W);
    endfunction

endpackage

// File: rtl/sdl_line_sync.sv
module sdl_line_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[TOP-1:0], d};
        end
    end

    assign q = pipe[TOP];

endmodule

// File: rtl/sdl_input_front.sv
module sdl_input_front #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic sdata_in,
    input  logic den_n_in,
    output logic bit_in,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic sclk_s;
    logic sdata_s;
    logic den_n_s;
    logic sclk_prev;

    sdl_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk (clk), .rst (rst), .d (sclk_in),  .q (sclk_s)
    );
    sdl_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk (clk), .rst (rst), .d (sdata_in), .q (sdata_s)
    );
    sdl_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_den (
        .clk (clk), .rst (rst), .d (den_n_in), .q (den_n_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;
    // Inactive enable forces a zero into the chain
    assign bit_in    = sdata_s & ~den_n_s;

endmodule

// File: rtl/sdl_shift_chain.sv
module sdl_shift_chain #(
    parameter int unsigned LEN = 36
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           clear_en,
    input  logic           bit_in,
    output logic [LEN-1:0] chain,
    output logic           full
);
    localparam int unsigned LAST = LEN - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (clear_en) begin
            // Stage 0 keeps any bit captured in the same cycle
            chain    <= '0;
            chain[0] <= shift_en & bit_in;
        end else if (shift_en) begin
            chain <= {chain[LAST-1:0], bit_in};
        end
    end

    assign full = chain[LAST];

endmodule

// File: rtl/sdl_frame_fsm.sv
module sdl_frame_fsm
    import sdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       full,
    input  logic       sclk_fall,
    output fsm_state_t state,
    output logic       latch_en,
    output logic       clear_en
);
    fsm_state_t state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT:   if (full)      state_nx = ST_HOLD_HIGH;  // T_FULL
            ST_HOLD_HIGH: if (sclk_fall) state_nx = ST_FLUSH;      // T_FALL
            ST_FLUSH:                    state_nx = ST_COLLECT;    // T_DONE
            default:                     state_nx = ST_COLLECT;
        endcase
    end

    // Outputs
    always_comb begin
        latch_en = 1'b0;
        clear_en = 1'b0;
        unique case (state)
            ST_COLLECT:   latch_en = full;
            ST_HOLD_HIGH: ;
            ST_FLUSH:     clear_en = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/sdl_out_latch.sv
module sdl_out_latch
    import sdl_pkg::*;
#(
    parameter int unsigned DW = 35,
    parameter int unsigned NW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch_en,
    input  logic [DW-1:0] chain_data,
    output logic [DW-1:0] seg_word,
    output logic [NW-1:0] seg_narrow,
    output logic          latch_strobe
);
    logic [DW-1:0] ordered;
    logic [NW-1:0] narrow_d;

    // Oldest data bit (frame bit 1) sits next to the start bit
    for (genvar i = 0; i < DW; i++) begin : g_order
        assign ordered[i] = chain_data[DW-1-i];
    end

    for (genvar j = 0; j < NW; j++) begin : g_narrow
        localparam int unsigned SRC = narrow_src(j);
        assign narrow_d[j] = ordered[SRC];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_word     <= '0;
            seg_narrow   <= '0;
            latch_strobe <= 1'b0;
        end else begin
            latch_strobe <= latch_en;
            if (latch_en) begin
                seg_word   <= ordered;
                seg_narrow <= narrow_d;
            end
        end
    end

endmodule

// File: rtl/serial_display_latch.sv
module serial_display_latch
    import sdl_pkg::*;
#(
    parameter int unsigned DW          = DATA_BITS,
    parameter int unsigned NW          = NARROW_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk_in,
    input  logic          sdata_in,
    input  logic          den_n_in,
    output logic [DW-1:0] seg_word,
    output logic [NW-1:0] seg_narrow,
    output logic          latch_strobe
);
    localparam int unsigned CHAIN_LEN = DW + 1;

    logic                 bit_in;
    logic                 sclk_rise;
    logic                 sclk_fall;
    logic [CHAIN_LEN-1:0] chain;
    logic                 full;
    logic                 latch_en;
    logic                 clear_en;
    fsm_state_t           fsm_state;

    sdl_input_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (sclk_in),
        .sdata_in  (sdata_in),
        .den_n_in  (den_n_in),
        .bit_in    (bit_in),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    sdl_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .clear_en (clear_en),
        .bit_in   (bit_in),
        .chain    (chain),
        .full     (full)
    );

    sdl_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .full      (full),
        .sclk_fall (sclk_fall),
        .state     (fsm_state),
        .latch_en  (latch_en),
        .clear_en  (clear_en)
    );

    sdl_out_latch #(.DW(DW), .NW(NW)) u_out (
        .clk          (clk),
        .rst          (rst),
        .latch_en     (latch_en),
        .chain_data   (chain[DW-1:0]),
        .seg_word     (seg_word),
        .seg_narrow   (seg_narrow),
        .latch_strobe (latch_strobe)
    );

endmodule

// File: rtl/sdl_checker.sv
module sdl_checker
    import sdl_pkg::*;
#(
    parameter int unsigned DW = 35,
    parameter int unsigned NW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] seg_word,
    input logic [NW-1:0] seg_narrow,
    input logic          latch_strobe,
    input logic          clear_en,
    input fsm_state_t    fsm_state
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: one edge after reset is seen, all outputs are off
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_clear_r1: assert (seg_word == '0 && seg_narrow == '0 && !latch_strobe)
                else $error("R1 outputs not cleared by reset");
        end
    end

    // R3: strobe lasts a single cycle
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        latch_strobe |=> !latch_strobe);

    // R4: the word never moves without a latch
    p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (seg_word != $past(seg_word)) |-> latch_strobe);

    // R8: narrow view moves only with a latch
    p_narrow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (seg_narrow != $past(seg_narrow)) |-> latch_strobe);

    // R6: a clear only follows the wait for the low phase after a latch
    p_clear_after_hold_r6: assert property (@(posedge clk) disable iff (rst)
        clear_en |-> ($past(fsm_state) == ST_HOLD_HIGH));

    // R6: after a latch the controller waits before collecting again
    p_strobe_then_hold_r6: assert property (@(posedge clk) disable iff (rst)
        latch_strobe |-> (fsm_state == ST_HOLD_HIGH));

endmodule

bind serial_display_latch sdl_checker #(.DW(DW), .NW(NW)) u_sdl_checker (
    .clk          (clk),
    .rst          (rst),
    .seg_word     (seg_word),
    .seg_narrow   (seg_narrow),
    .latch_strobe (latch_strobe),
    .clear_en     (clear_en),
    .fsm_state    (fsm_state)
);

// File: tb/test_serial_display_latch.sv
`timescale 1ns/1ps
module test_serial_display_latch;

    localparam int DW   = 35;
    localparam int NW   = 14;
    localparam int HALF = 6;      // system cycles per serial clock phase

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk_in = 1'b0;
    logic          sdata_in = 1'b0;
    logic          den_n_in = 1'b1;
    logic [DW-1:0] seg_word;
    logic [NW-1:0] seg_narrow;
    logic          latch_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int strobe_cnt = 0;

    // Reference state built from the requirements
    logic [DW:0]   ref_chain = '0;
    logic [DW-1:0] ref_seg   = '0;

    always #4 clk = ~clk;   // 125 MHz

    serial_display_latch i_serial_display_latch (
        .clk          (clk),
        .rst          (rst),
        .sclk_in      (sclk_in),
        .sdata_in     (sdata_in),
        .den_n_in     (den_n_in),
        .seg_word     (seg_word),
        .seg_narrow   (seg_narrow),
        .latch_strobe (latch_strobe)
    );

    always @(negedge clk) if (!rst && latch_strobe) strobe_cnt++;

    function automatic logic [NW-1:0] exp_narrow(input logic [DW-1:0] w);
        logic [NW-1:0] n;
        for (int j = 0; j < NW; j++) n[j] = w[4 + 8*(j/4) + (j%4)];
        return n;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic den_n);
        int   s0;
        logic v;
        logic latched;
        s0 = strobe_cnt;
        @(negedge clk);
        sdata_in = b;
        den_n_in = den_n;
        repeat (HALF) @(negedge clk);
        sclk_in = 1'b1;
        repeat (HALF/2) @(negedge clk);
        // R9: toggling during the high phase must be ignored
        sdata_in = ~b;
        den_n_in = ~den_n;
        repeat (HALF - HALF/2) @(negedge clk);
        sclk_in = 1'b0;
        repeat (HALF) @(negedge clk);
        // reference model
        v = den_n ? 1'b0 : b;   // R5
        ref_chain = {ref_chain[DW-1:0], v};
        latched = ref_chain[DW];
        if (latched) begin
            for (int i = 0; i < DW; i++) ref_seg[i] = ref_chain[DW-1-i];
            ref_chain = '0;     // R6
        end
        check(seg_word == ref_seg, latched ? "R2 word" : "R4 hold word",
              64'(seg_word), 64'(ref_seg));
        check(seg_narrow == exp_narrow(ref_seg), "R8 narrow",
              64'(seg_narrow), 64'(exp_narrow(ref_seg)));
        check((strobe_cnt - s0) == (latched ? 1 : 0), "R3 strobe count",
              64'(strobe_cnt - s0), latched ? 64'd1 : 64'd0);
    endtask

    task automatic send_frame(input logic [DW-1:0] d);
        send_bit(1'b1, 1'b0);
        for (int k = 0; k < DW; k++) send_bit(d[k], 1'b0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] lfsr;
        logic [DW-1:0] held;
        int s0;

        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1
        check(seg_word == '0, "R1 word", 64'(seg_word), 64'd0);
        check(seg_narrow == '0, "R1 narrow", 64'(seg_narrow), 64'd0);
        check(latch_strobe == 1'b0, "R1 strobe", 64'(latch_strobe), 64'd0);

        // R2 / R8: walking one across every data position
        for (int p = 0; p < DW; p++) send_frame(DW'(1) << p);

        // Dense and mixed patterns
        send_frame('1);
        // R6: leftover ones must not form a phantom frame
        s0 = strobe_cnt;
        for (int k = 0; k < 40; k++) send_bit(1'b0, 1'b0);
        check(strobe_cnt == s0, "R6 no phantom latch", 64'(strobe_cnt - s0), 64'd0);
        check(seg_word == '1, "R6 word kept", 64'(seg_word), 64'(ref_seg));

        send_frame({18{2'b01}});
        lfsr = 35'h4A5C3E17;
        for (int f = 0; f < 5; f++) begin
            for (int s = 0; s < 7; s++) lfsr = {lfsr[DW-2:0], lfsr[DW-1] ^ lfsr[DW-3]};
            send_frame(lfsr);
        end

        // R7: back-to-back frames
        send_frame(35'h123456789);
        send_frame(35'h6DB6DB6DB);
        check(seg_word == 35'h6DB6DB6DB, "R7 second frame", 64'(seg_word), 64'h6DB6DB6DB);

        // R5: inactive enable shifts zeros only
        held = seg_word;
        s0 = strobe_cnt;
        for (int k = 0; k < 36; k++) send_bit(1'b1, 1'b1);
        check(strobe_cnt == s0, "R5 no start seen", 64'(strobe_cnt - s0), 64'd0);
        check(seg_word == held, "R5 word held", 64'(seg_word), 64'(held));
        send_bit(1'b1, 1'b0);
        for (int k = 0; k < DW; k++) send_bit(1'b1, 1'b1);
        check(seg_word == '0, "R5 zeros latched", 64'(seg_word), 64'd0);

        // R4: truncated frame
        send_frame(35'h2F0F0F0F1);
        held = seg_word;
        s0 = strobe_cnt;
        send_bit(1'b1, 1'b0);
        for (int k = 0; k < 20; k++) send_bit(1'b1, 1'b0);
        check(strobe_cnt == s0, "R4 no latch", 64'(strobe_cnt - s0), 64'd0);
        check(seg_word == held, "R4 word held", 64'(seg_word), 64'(held));

        // R10: blanking sequence after the partial frame
        for (int k = 0; k < 36; k++) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        for (int k = 0; k < 36; k++) send_bit(1'b0, 1'b0);
        check(seg_word == '0, "R10 blank word", 64'(seg_word), 64'd0);
        check(seg_narrow == '0, "R10 blank narrow", 64'(seg_narrow), 64'd0);

        finish_run();
    end

endmodule